// File: doc/BRIEF.md
# ARINC Word Repeater Host Interface

This block sits between the serial receive path of an ARINC 429 channel and a 16-bit host bus. A decoded 32-bit word, presented with a one-cycle valid strobe, is captured in a receive holding register. The host reads the word as two 16-bit halves, and a select input chooses which half appears on the read data bus. A received-data-ready flag tells the host that an unread word is waiting.

When the repeater bit of the control register is set, every half the host reads is also written into a transmit FIFO. The lower half is written first and is held pending until the upper half completes the word, so the FIFO only ever holds whole 32-bit words. The FIFO offers a word-wide read port with a pop strobe for the transmit serializer, and it has empty and full flags. Reading the halves in the wrong order in repeater mode, or completing a word while the FIFO is full, sets a sticky error flag. A master reset input stops reception and clears the FIFO, the pending half and the flags, but keeps the control register.

Top module: `arinc_rpt_host`

## Requirements
- R1: `rd_data` always shows the lower half (bits 15:0) of the held word when `rd_hi`=0 and the upper half (bits 31:16) when `rd_hi`=1. With control bit 5 clear (normal mode), either half may be read first and no read writes the FIFO.
- R2: `rx_ready` is 1 from the cycle after a `rx_valid` strobe. It returns to 0 once both halves have been read with `rd_en`, in either order and in either mode. Reading one half repeatedly does not clear it. A new word clears the record of which halves have been read.
- R3: With control bit 5 set (repeater mode), a lower read followed by an upper read commits one word {upper, lower} to the FIFO. `tx_empty` falls in the cycle after the upper read, and `tx_word` shows the oldest word.
- R4: In repeater mode, an upper read with no pending lower half writes nothing to the FIFO and sets `order_err`. The flag stays at 1 until master reset.
- R5: The FIFO holds 8 words and `tx_full` is 1 when it holds 8. A word completed while the FIFO is full is dropped, `ovf_err` is set and stays at 1, and the stored words are unchanged.
- R6: `tx_rd` removes the oldest word, and words leave in the order they were committed.
- R7: A master reset pulse (`mres`=1) empties the FIFO, discards a pending lower half, and clears `rx_ready`, `order_err` and `ovf_err`. It leaves `ctl_q` unchanged.
- R8: Each of the 16 control bits, bit 13 included, is written by `ctl_wr` and read back on `ctl_q`. Bit 13 has no effect inside the block.
- R9: The chip reset `rst_n`=0 clears the control register and all flags: `tx_empty`=1 and every other flag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| mres | input | 1 | Master reset, synchronous, active high |
| rx_word | input | 32 | Decoded receive word |
| rx_valid | input | 1 | One-cycle strobe capturing `rx_word` |
| rd_en | input | 1 | Host read strobe for one half |
| rd_hi | input | 1 | Half select: 0 lower, 1 upper |
| rd_data | output | 16 | Selected half of the held word |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control register write data (bit 5 = repeater mode) |
| ctl_q | output | 16 | Control register contents |
| rx_ready | output | 1 | Unread received word present |
| tx_rd | input | 1 | Pop strobe for the transmit FIFO |
| tx_word | output | 32 | Oldest FIFO word |
| tx_empty | output | 1 | FIFO empty |
| tx_full | output | 1 | FIFO full |
| order_err | output | 1 | Sticky: upper half read first in repeater mode |
| ovf_err | output | 1 | Sticky: word dropped because the FIFO was full |

## Verification
A vector table runs words with distinct upper and lower halves through both modes and both read orders. This shows whether the select input picks the correct half, whether the ready flag waits for both halves, and whether the FIFO receives exactly one correctly assembled word only in the lower-first repeater case. Directed runs fill the FIFO past its depth to separate the full flag from the drop-and-flag behaviour and to check pop order. A master reset is placed between a lower and an upper read to show that the pending half is lost while the control register keeps its value. A word that arrives between two reads checks that the read tracking restarts.

// File: rtl/arinc_rpt_pkg.sv
package arinc_rpt_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;

  typedef logic [HALF_W-1:0] half_t;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_sel_e;
endpackage

// File: rtl/arinc_rpt_ctl.sv
module arinc_rpt_ctl #(
  parameter int CTL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  output logic [CTL_W-1:0] q
);
  logic [CTL_W-1:0] q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (wr) q_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else if (wr) q_q <= q_d;
  end

  assign q = q_q;

  // R8: the register only changes on a write strobe (master reset has no path here)
  p_ctl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(q));
endmodule

// File: rtl/arinc_rpt_rxlatch.sv
module arinc_rpt_rxlatch
  import arinc_rpt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      load,
  input  word_t     word_in,
  input  logic      rd_en,
  input  half_sel_e rd_sel,
  output half_t     rd_half,
  output logic      ready
);
  word_t       word_q, word_d;
  logic        ready_q, ready_d;
  logic [1:0]  seen_q, seen_d;

  always_comb begin
    word_d  = word_q;
    ready_d = ready_q;
    seen_d  = seen_q;
    if (clr) begin
      word_d  = '0;
      ready_d = 1'b0;
      seen_d  = '0;
    end else if (load) begin
      word_d  = word_in;
      ready_d = 1'b1;
      seen_d  = '0;
    end else if (rd_en && ready_q) begin
      if (rd_sel == HALF_HI) seen_d[1] = 1'b1;
      else                   seen_d[0] = 1'b1;
      if (&seen_d) begin
        ready_d = 1'b0;
        seen_d  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      ready_q <= 1'b0;
      seen_q  <= '0;
    end else begin
      word_q  <= word_d;
      ready_q <= ready_d;
      seen_q  <= seen_d;
    end
  end

  assign rd_half = (rd_sel == HALF_HI) ? word_q[WORD_W-1:HALF_W] : word_q[HALF_W-1:0];
  assign ready   = ready_q;

  // R2: a captured word raises the ready flag in the next cycle
  p_ready_after_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> ready);
endmodule

// File: rtl/arinc_rpt_fifo.sv
module arinc_rpt_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH):0]     level
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = AW + 1;

  logic [W-1:0]     mem [DEPTH];
  logic [AW-1:0]    wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (clr) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = wp_q + 1'b1;
      if (do_pop)  rp_d = rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_push && (wp_q == AW'(gi))) mem[gi] <= din;
    end
  end

  assign dout  = mem[rp_q];
  assign level = cnt_q;

  // R5: occupancy never exceeds the depth
  p_level_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CNT_W'(DEPTH));
  // R5: a push into a full FIFO without a pop leaves the occupancy alone
  p_full_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !clr) |=> $stable(level));
endmodule

// File: rtl/arinc_rpt_host.sv
module arinc_rpt_host
  import arinc_rpt_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int CTL_W      = 16,
  parameter int RPT_BIT    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mres,
  input  logic [31:0]       rx_word,
  input  logic              rx_valid,
  input  logic              rd_en,
  input  logic              rd_hi,
  output logic [15:0]       rd_data,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic [CTL_W-1:0]  ctl_q,
  output logic              rx_ready,
  input  logic              tx_rd,
  output logic [31:0]       tx_word,
  output logic              tx_empty,
  output logic              tx_full,
  output logic              order_err,
  output logic              ovf_err
);
  localparam int LVL_W = $clog2(FIFO_DEPTH) + 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  arinc_rpt_ctl #(.CTL_W(CTL_W)) u_ctl (
    .clk   (clk),
    .rst_n (rst_ni),
    .wr    (ctl_wr),
    .wdata (ctl_wdata),
    .q     (ctl_q)
  );

  half_t     half_rd;
  half_sel_e sel;
  assign sel = half_sel_e'(rd_hi);

  arinc_rpt_rxlatch u_rx (
    .clk     (clk),
    .rst_n   (rst_ni),
    .clr     (mres),
    .load    (rx_valid),
    .word_in (rx_word),
    .rd_en   (rd_en),
    .rd_sel  (sel),
    .rd_half (half_rd),
    .ready   (rx_ready)
  );
  assign rd_data = half_rd;

  // repeater path
  logic       rpt_mode, rd_act, lo_wr, hi_wr, commit, push;
  logic       pend_v_q, pend_v_d;
  half_t      pend_lo_q, pend_lo_d;
  logic       oerr_q, oerr_d, ovf_q, ovf_d;
  logic [LVL_W-1:0] level;

  assign rpt_mode = ctl_q[RPT_BIT];
  assign rd_act   = rd_en && !mres;
  assign lo_wr    = rd_act && rpt_mode && (sel == HALF_LO);
  assign hi_wr    = rd_act && rpt_mode && (sel == HALF_HI);
  assign commit   = hi_wr && pend_v_q;
  assign push     = commit && !tx_full;

  always_comb begin
    pend_v_d  = pend_v_q;
    pend_lo_d = pend_lo_q;
    oerr_d    = oerr_q;
    ovf_d     = ovf_q;
    if (mres) begin
      pend_v_d = 1'b0;
      oerr_d   = 1'b0;
      ovf_d    = 1'b0;
    end else begin
      if (lo_wr) begin
        pend_v_d  = 1'b1;
        pend_lo_d = half_rd;
      end else if (hi_wr) begin
        pend_v_d = 1'b0;
      end
      if (hi_wr && !pend_v_q)     oerr_d = 1'b1;
      if (commit && tx_full)      ovf_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v_q <= 1'b0;
      oerr_q   <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      pend_v_q <= pend_v_d;
      oerr_q   <= oerr_d;
      ovf_q    <= ovf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    pend_lo_q <= '0;
    else if (lo_wr) pend_lo_q <= pend_lo_d;
  end

  assign order_err = oerr_q;
  assign ovf_err   = ovf_q;

  arinc_rpt_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_ni),
    .clr   (mres),
    .push  (push),
    .din   ({half_rd, pend_lo_q}),
    .pop   (tx_rd),
    .dout  (tx_word),
    .empty (tx_empty),
    .full  (tx_full),
    .level (level)
  );

  // R3: a completed word with room makes the FIFO non-empty next cycle
  p_commit_fills_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (commit && !tx_full && !mres) |=> !tx_empty);
  // R4: an upper read with nothing pending flags an order error
  p_upper_first_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (hi_wr && !pend_v_q) |=> order_err);
  // R4: the order error is sticky until master reset
  p_order_sticky_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (order_err && !mres) |=> order_err);
  // R5: completing a word into a full FIFO raises the overflow flag
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (commit && tx_full) |=> (ovf_err && $stable(level)));
  // R7: master reset leaves the receive and transmit side idle
  p_mres_clears_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    mres |=> (tx_empty && !rx_ready && !order_err && !ovf_err && !pend_v_q));
endmodule

// File: tb/tb_arinc_rpt_host.sv
module tb_arinc_rpt_host;
  logic        clk = 1'b0;
  logic        rst_n, mres, rx_valid, rd_en, rd_hi, ctl_wr, tx_rd;
  logic [31:0] rx_word;
  logic [15:0] ctl_wdata, ctl_q, rd_data;
  logic [31:0] tx_word;
  logic        rx_ready, tx_empty, tx_full, order_err, ovf_err;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  arinc_rpt_host dut (
    .clk(clk), .rst_n(rst_n), .mres(mres), .rx_word(rx_word), .rx_valid(rx_valid),
    .rd_en(rd_en), .rd_hi(rd_hi), .rd_data(rd_data), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .ctl_q(ctl_q), .rx_ready(rx_ready), .tx_rd(tx_rd),
    .tx_word(tx_word), .tx_empty(tx_empty), .tx_full(tx_full),
    .order_err(order_err), .ovf_err(ovf_err)
  );

  typedef struct packed {
    logic [31:0] word;
    logic        rpt;
    logic        hi_first;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{32'hA5A5_1234, 1'b0, 1'b0},
    '{32'hDEAD_BEEF, 1'b0, 1'b1},
    '{32'h0000_FFFF, 1'b1, 1'b0},
    '{32'h8001_7FFE, 1'b1, 1'b1},
    '{32'hFFFF_0000, 1'b1, 1'b0},
    '{32'h1357_9BDF, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic set_ctl(input logic [15:0] v);
    ctl_wdata = v; ctl_wr = 1'b1;
    tick();
    ctl_wr = 1'b0;
  endtask

  task automatic send(input logic [31:0] w);
    rx_word = w; rx_valid = 1'b1;
    tick();
    rx_valid = 1'b0;
  endtask

  task automatic host_read(input logic hi, output logic [15:0] d);
    rd_hi = hi; rd_en = 1'b1;
    #1 d = rd_data;
    tick();
    rd_en = 1'b0;
  endtask

  task automatic pulse_mres();
    mres = 1'b1;
    tick();
    mres = 1'b0;
  endtask

  task automatic pop();
    tx_rd = 1'b1;
    tick();
    tx_rd = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired (R1..): actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [31:0] w;
    rst_n = 1'b0; mres = 1'b0; rx_valid = 1'b0; rd_en = 1'b0; rd_hi = 1'b0;
    ctl_wr = 1'b0; ctl_wdata = '0; tx_rd = 1'b0; rx_word = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) tick();

    // R9: reset state
    chk("R9 ctl", {16'h0, ctl_q}, 32'h0);
    chk("R9 flags", {27'h0, rx_ready, tx_empty, tx_full, order_err, ovf_err}, 32'h8);

    // vector table: modes and read orders
    for (int i = 0; i < NVEC; i++) begin
      set_ctl(VECS[i].rpt ? 16'h0020 : 16'h0000);
      send(VECS[i].word);
      chk("R2 ready set", {31'h0, rx_ready}, 32'h1);
      host_read(VECS[i].hi_first, d);
      chk("R1 first half", {16'h0, d},
          VECS[i].hi_first ? {16'h0, VECS[i].word[31:16]} : {16'h0, VECS[i].word[15:0]});
      chk("R2 ready after one half", {31'h0, rx_ready}, 32'h1);
      host_read(!VECS[i].hi_first, d);
      chk("R1 second half", {16'h0, d},
          VECS[i].hi_first ? {16'h0, VECS[i].word[15:0]} : {16'h0, VECS[i].word[31:16]});
      chk("R2 ready cleared", {31'h0, rx_ready}, 32'h0);
      if (VECS[i].rpt && !VECS[i].hi_first) begin
        chk("R3 fifo filled", {31'h0, tx_empty}, 32'h0);
        chk("R3 word", tx_word, VECS[i].word);
        pop();
        chk("R6 popped empty", {31'h0, tx_empty}, 32'h1);
      end else if (VECS[i].rpt) begin
        chk("R4 order err", {31'h0, order_err}, 32'h1);
        chk("R4 no write", {31'h0, tx_empty}, 32'h1);
        pulse_mres();
        chk("R4 cleared by mres", {31'h0, order_err}, 32'h0);
      end else begin
        chk("R1 normal no write", {31'h0, tx_empty}, 32'h1);
        chk("R1 no order err", {31'h0, order_err}, 32'h0);
      end
    end

    // R2: a new word restarts the half tracking
    set_ctl(16'h0000);
    send(32'h1111_2222);
    host_read(1'b0, d);
    host_read(1'b0, d);
    chk("R2 same half twice", {31'h0, rx_ready}, 32'h1);
    send(32'h3333_4444);
    host_read(1'b1, d);
    chk("R2 tracking restarted", {31'h0, rx_ready}, 32'h1);
    chk("R1 new word upper", {16'h0, d}, 32'h3333);
    host_read(1'b0, d);
    chk("R2 both halves of new word", {31'h0, rx_ready}, 32'h0);

    // R5 / R6: fill past depth
    set_ctl(16'h0020);
    for (int k = 0; k < 9; k++) begin
      send(32'hC000_0000 + k);
      host_read(1'b0, d);
      host_read(1'b1, d);
      if (k == 7) begin
        chk("R5 full at 8", {31'h0, tx_full}, 32'h1);
        chk("R5 no ovf yet", {31'h0, ovf_err}, 32'h0);
      end
    end
    chk("R5 ovf set", {31'h0, ovf_err}, 32'h1);
    chk("R5 still full", {31'h0, tx_full}, 32'h1);
    for (int k = 0; k < 8; k++) begin
      chk("R6 order", tx_word, 32'hC000_0000 + k);
      pop();
    end
    chk("R5 ninth dropped", {31'h0, tx_empty}, 32'h1);
    chk("R5 ovf sticky", {31'h0, ovf_err}, 32'h1);

    // R7: master reset with one word stored and one half pending
    set_ctl(16'h2020);
    send(32'hAAAA_5555);
    host_read(1'b0, d);
    host_read(1'b1, d);
    send(32'hBBBB_6666);
    host_read(1'b0, d);
    chk("R7 ready before mres", {31'h0, rx_ready}, 32'h1);
    pulse_mres();
    chk("R7 fifo emptied", {31'h0, tx_empty}, 32'h1);
    chk("R7 flags cleared", {29'h0, rx_ready, order_err, ovf_err}, 32'h0);
    chk("R7 ctl kept", {16'h0, ctl_q}, 32'h2020);
    host_read(1'b1, d);
    chk("R7 pending discarded", {31'h0, tx_empty}, 32'h1);
    chk("R7 upper now out of order", {31'h0, order_err}, 32'h1);
    pulse_mres();

    // R8: every control bit, bit 13 inert
    set_ctl(16'h2000);
    chk("R8 bit13", {16'h0, ctl_q}, 32'h2000);
    send(32'h0F0F_F0F0);
    host_read(1'b0, d);
    host_read(1'b1, d);
    chk("R8 bit13 no repeat", {31'h0, tx_empty}, 32'h1);
    set_ctl(16'hFFDF);
    chk("R8 all bits", {16'h0, ctl_q}, 32'hFFDF);
    set_ctl(16'h5A5A);
    chk("R8 pattern", {16'h0, ctl_q}, 32'h5A5A);

    // R9: chip reset clears the control register
    set_ctl(16'h2020);
    send(32'h1234_5678);
    rst_n = 1'b0;
    repeat (2) tick();
    chk("R9 ctl cleared", {16'h0, ctl_q}, 32'h0);
    chk("R9 ready cleared", {31'h0, rx_ready}, 32'h0);
    rst_n = 1'b1;
    repeat (3) tick();
    chk("R9 empty after reset", {31'h0, tx_empty}, 32'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule